// File: doc/BRIEF.md
# Serial-Fed Biphase/Manchester Encoder

This block drives the damping modulator of a contactless transponder front end from a plain two-wire bus. The two-wire front end decodes a special-mode control byte and, once that byte has been acknowledged, issues a single-cycle `mode_go` pulse. The pulse comes with a code select taken from bit 4 of the byte: 1100x111 asks for Biphase and 1101x111 asks for Manchester. From then on the bus carries a raw bit stream. Each SCL high phase is the first half of a bit cell and each SCL low phase is the second half. SDA carries the bit value. The block turns this stream into a coded damping level on `mod_out`, where high means the coil is damped and low means it is left undamped.

The stream has no byte boundaries and no acknowledge slots, so any number of cells may follow one another. A STOP condition on the bus (SDA rising while SCL is high) leaves coded mode. Outside coded mode the output simply follows the direct `mod_in` input, so a host can still key the damping stage by hand. SCL and SDA pass through a parameterised synchroniser before any edge is detected.

Top module: `dmod_encoder`

## Requirements
- R1: While coded mode is inactive (after reset, after a STOP, or during reset) `mod_out` equals `mod_in`.
- R2: A `mode_go` pulse enters coded mode with the output at the idle level 0 (undamped) until the first cell begins. While the mode is active, `mod_in` has no effect on `mod_out`.
- R3: A cell begins on an SCL rising edge, and its mid-point is the following SCL falling edge. The bit is sampled from SDA at the rising edge. In coded mode the output changes only at these edges, so SDA activity at any other time leaves it unchanged.
- R4: In Biphase coding (`mode_sel`=0) the output inverts at every cell start and inverts once more at mid-cell when the bit is 0.
- R5: In Manchester coding (`mode_sel`=1) a 1 bit is sent high then low and a 0 bit is sent low then high.
- R6: Cells follow each other without framing, and the ninth and later bits are coded exactly like the first eight.
- R7: SDA rising while SCL is high ends coded mode. SDA falling while SCL is high neither ends the mode nor changes the output.
- R8: The code select is captured at `mode_go`. Changes on `mode_sel` while the mode is active have no effect.
- R9: An SCL falling edge seen after `mode_go` but before any SCL rising edge leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| scl_in | input | 1 | Bus clock line; in coded mode it is the bit clock |
| sda_in | input | 1 | Bus data line; in coded mode it is the bit data |
| mod_in | input | 1 | Direct damping request, passed through when coded mode is inactive |
| mode_go | input | 1 | Single-cycle pulse from the two-wire front end that enters coded mode |
| mode_sel | input | 1 | Code select captured at mode_go: 0 for Biphase, 1 for Manchester |
| mod_out | output | 1 | Damping level: 1 damped, 0 undamped |

## Verification
The checker assumes that `mode_go` is a clean single-cycle pulse in the clk domain. It also assumes that SCL and SDA phases outlast the synchroniser depth plus the edge register, so that a rising and a falling edge never fall in the same cycle, and that SDA moves while SCL is high only to form a START or STOP. The stimulus holds every bus phase for eight clocks. It changes SDA only while SCL is low, except in the deliberate START-like and STOP sequences. It issues `mode_go` while SCL is low in every case but one, the R9 corner, which raises the pulse while SCL is high so that a falling edge arrives before any cell has opened.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

   typedef enum logic {
      CODE_BIPHASE = 1'b0,
      CODE_MANCH   = 1'b1
   } code_t;

   // level taken at the opening edge of a cell
   function automatic logic lvl_at_start(code_t c, logic cur, logic d);
      return (c == CODE_BIPHASE) ? ~cur : d;
   endfunction

   // level taken at the mid-cell edge, given the bit latched at the start
   function automatic logic lvl_at_mid(code_t c, logic cur, logic b);
      if (c == CODE_BIPHASE) return b ? cur : ~cur;
      return ~b;
   endfunction

endpackage

// File: rtl/dmod_sync.sv
module dmod_sync #(
   parameter int              WIDTH   = 2,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("dmod_sync: STAGES must lie in 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] st [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end

endmodule

// File: rtl/dmod_edges.sv
module dmod_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic stop_seen
);

   logic scl_d;
   logic sda_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_d;
   assign scl_fall  = ~scl_s &  scl_d;
   // data line rising while the clock stayed high on both samples
   assign stop_seen =  scl_s &  scl_d & sda_s & ~sda_d;

endmodule

// File: rtl/dmod_cell_coder.sv
module dmod_cell_coder
   import dmod_pkg::*;
#(
   parameter logic IDLE_LEVEL = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  mode_go,
   input  code_t mode_sel,
   input  logic  stop_seen,
   input  logic  scl_rise,
   input  logic  scl_fall,
   input  logic  sda_s,
   output logic  active,
   output code_t code_q,
   output logic  cell_open,
   output logic  level
);

   logic bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         code_q    <= CODE_BIPHASE;
         cell_open <= 1'b0;
         bit_q     <= 1'b0;
         level     <= IDLE_LEVEL;
      end else if (mode_go) begin
         active    <= 1'b1;
         code_q    <= mode_sel;
         cell_open <= 1'b0;
         bit_q     <= 1'b0;
         level     <= IDLE_LEVEL;
      end else if (active) begin
         if (stop_seen) begin
            active    <= 1'b0;
            cell_open <= 1'b0;
            level     <= IDLE_LEVEL;
         end else if (scl_rise) begin
            bit_q     <= sda_s;
            cell_open <= 1'b1;
            level     <= lvl_at_start(code_q, level, sda_s);
         end else if (scl_fall && cell_open) begin
            level     <= lvl_at_mid(code_q, level, bit_q);
         end
      end
   end

endmodule

// File: rtl/dmod_encoder.sv
module dmod_encoder
   import dmod_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic mod_in,
   input  logic mode_go,
   input  logic mode_sel,
   output logic mod_out
);

   localparam int BUS_W = 2;

   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("dmod_encoder: SYNC_STAGES above 4 is not supported");
   end

   logic [BUS_W-1:0] bus_s;
   logic  scl_rise, scl_fall, stop_seen;
   logic  active, cell_open, level;
   code_t code_q;

   dmod_sync #(
      .WIDTH   (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({BUS_W{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (bus_s)
   );

   dmod_edges u_edges (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (bus_s[1]),
      .sda_s     (bus_s[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .stop_seen (stop_seen)
   );

   dmod_cell_coder #(
      .IDLE_LEVEL (IDLE_LEVEL)
   ) u_coder (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_go   (mode_go),
      .mode_sel  (code_t'(mode_sel)),
      .stop_seen (stop_seen),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_s     (bus_s[0]),
      .active    (active),
      .code_q    (code_q),
      .cell_open (cell_open),
      .level     (level)
   );

   assign mod_out = active ? level : mod_in;

endmodule

// File: rtl/dmod_encoder_chk.sv
module dmod_encoder_chk
   import dmod_pkg::*;
#(
   parameter logic IDLE_LEVEL = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic mode_go,
   input logic mod_out,
   input logic active,
   input logic code,
   input logic cell_open,
   input logic level,
   input logic scl_rise,
   input logic scl_fall,
   input logic stop_seen
);

   // R2: entry starts at the idle level
   p_entry_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_go |=> (mod_out == IDLE_LEVEL));

   // R3: no bus clock edge, no output change
   p_quiet_between_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !mode_go && !scl_rise && !scl_fall && !stop_seen) |=> $stable(mod_out));

   // R4: Biphase always inverts at a cell start
   p_biphase_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !mode_go && !stop_seen && code == CODE_BIPHASE && scl_rise)
      |=> (mod_out != $past(mod_out)));

   // R5: Manchester always inverts at mid-cell
   p_manch_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !mode_go && code == CODE_MANCH && scl_fall && cell_open)
      |=> (mod_out != $past(mod_out)));

   // R7: STOP leaves coded mode
   p_stop_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !mode_go && stop_seen) |=> !active);

   // R8: code select frozen while active
   p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !mode_go) |=> (code == $past(code)));

   // R9: a falling edge before any cell leaves the level alone
   p_early_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !mode_go && scl_fall && !cell_open) |=> $stable(level));

endmodule

bind dmod_encoder dmod_encoder_chk #(.IDLE_LEVEL(IDLE_LEVEL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_go   (mode_go),
   .mod_out   (mod_out),
   .active    (active),
   .code      (code_q),
   .cell_open (cell_open),
   .level     (level),
   .scl_rise  (scl_rise),
   .scl_fall  (scl_fall),
   .stop_seen (stop_seen)
);

// File: tb/sim_dmod_encoder.sv
module sim_dmod_encoder;

   localparam int HOLD  = 8;
   localparam int NVEC  = 5;
   // {mode_sel, 8-bit pattern sent MSB first, 16-bit waveform: (first half, second half) per cell}
   localparam logic [24:0] VEC [NVEC] = '{
      {1'b0, 8'hFF, 16'hCCCC},
      {1'b0, 8'h00, 16'hAAAA},
      {1'b1, 8'hA5, 16'h9966},
      {1'b0, 8'hA5, 16'hD2B4},
      {1'b1, 8'h0F, 16'h55AA}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1, mod_in = 1'b0, mode_go = 1'b0, mode_sel = 1'b0;
   logic mod_out;
   int   checks = 0;
   int   fails  = 0;

   always #2 clk = ~clk;

   dmod_encoder u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl),
      .sda_in   (sda),
      .mod_in   (mod_in),
      .mode_go  (mode_go),
      .mode_sel (mode_sel),
      .mod_out  (mod_out)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic go(input logic sel);
      mode_sel = sel;
      mode_go  = 1'b1;
      @(negedge clk);
      mode_go  = 1'b0;
      wait_n(2);
   endtask

   task automatic drive_bit(input logic b, output logic h1, output logic h2);
      sda = b;
      wait_n(HOLD);
      scl = 1'b1;
      wait_n(HOLD);
      h1 = mod_out;
      scl = 1'b0;
      wait_n(HOLD);
      h2 = mod_out;
   endtask

   task automatic stop_seq();
      sda = 1'b0;
      wait_n(HOLD);
      scl = 1'b1;
      wait_n(HOLD);
      sda = 1'b1;
      wait_n(HOLD);
   endtask

   initial begin
      logic h1, h2;
      logic [9:0] run;
      // R1: passthrough during and after reset
      mod_in = 1'b1;
      wait_n(4);
      chk("R1 reset passthrough high", mod_out, 1'b1);
      mod_in = 1'b0;
      wait_n(1);
      chk("R1 reset passthrough low", mod_out, 1'b0);
      rst_n = 1'b1;
      mod_in = 1'b1;
      wait_n(4);
      chk("R1 idle passthrough", mod_out, 1'b1);

      // vector table: R4 Biphase, R5 Manchester, R1 after STOP
      for (int i = 0; i < NVEC; i++) begin
         scl = 1'b0;
         wait_n(HOLD);
         go(VEC[i][24]);
         for (int j = 7; j >= 0; j--) begin
            drive_bit(VEC[i][16+j], h1, h2);
            chk(VEC[i][24] ? "R5 vec first half" : "R4 vec first half", h1, VEC[i][2*j+1]);
            chk(VEC[i][24] ? "R5 vec second half" : "R4 vec second half", h2, VEC[i][2*j]);
         end
         stop_seq();
         mod_in = 1'b1;
         wait_n(2);
         chk("R1 after STOP high", mod_out, 1'b1);
         mod_in = 1'b0;
         wait_n(2);
         chk("R1 after STOP low", mod_out, 1'b0);
      end

      // R2 entry level, mod_in ignored; R3 SDA while SCL low ignored
      scl = 1'b0;
      wait_n(HOLD);
      mod_in = 1'b1;
      go(1'b1);
      chk("R2 entry idle level", mod_out, 1'b0);
      for (int k = 0; k < 4; k++) begin
         sda = ~sda;
         wait_n(HOLD);
         chk("R3 SDA with SCL low no effect", mod_out, 1'b0);
      end
      // R8: switching mode_sel to Biphase while active changes nothing
      mode_sel = 1'b0;
      drive_bit(1'b1, h1, h2);
      chk("R8 select frozen first half", h1, 1'b1);
      chk("R8 select frozen second half", h2, 1'b0);
      // R6: continuous stream past eight bits
      run = 10'b1100110101;
      for (int k = 9; k >= 0; k--) begin
         drive_bit(run[k], h1, h2);
         chk("R6 unframed first half", h1, run[k]);
         chk("R6 unframed second half", h2, ~run[k]);
      end
      mod_in = 1'b0;
      wait_n(2);
      chk("R2 mod_in ignored while active", mod_out, 1'b0);
      stop_seq();

      // R7: START-like SDA fall during SCL high is ignored
      scl = 1'b0;
      wait_n(HOLD);
      mod_in = 1'b0;
      go(1'b0);
      sda = 1'b1;
      wait_n(HOLD);
      scl = 1'b1;
      wait_n(HOLD);
      chk("R4 cell start inverts", mod_out, 1'b1);
      sda = 1'b0;
      wait_n(HOLD);
      chk("R7 SDA fall with SCL high keeps mode", mod_out, 1'b1);
      scl = 1'b0;
      wait_n(HOLD);
      chk("R3 bit sampled at rising edge", mod_out, 1'b1);
      stop_seq();
      chk("R7 STOP exits low", mod_out, 1'b0);
      mod_in = 1'b1;
      wait_n(2);
      chk("R7 STOP exits high", mod_out, 1'b1);

      // R9: falling edge before the first cell
      mod_in = 1'b1;
      go(1'b1);
      scl = 1'b0;
      wait_n(HOLD);
      chk("R9 early fall ignored", mod_out, 1'b0);
      drive_bit(1'b0, h1, h2);
      chk("R9 first cell first half", h1, 1'b0);
      chk("R9 first cell second half", h2, 1'b1);

      // R1: reset in the middle of coded mode
      rst_n = 1'b0;
      wait_n(3);
      chk("R1 reset mid-mode", mod_out, 1'b1);
      rst_n = 1'b1;
      mod_in = 1'b0;
      wait_n(3);
      chk("R1 after reset mid-mode", mod_out, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule